// File: doc/BRIEF.md
# Audio Frame Step Sequencer with Interrupt

This block paces the slow-rate units of an audio generator. A cycle counter advances once per CPU clock. At a fixed set of irregular counts it fires a quarter-frame pulse, a half-frame pulse, or both. The consumers are envelope, length and sweep logic outside this block. Two sequence lengths can be selected. The short 4-step sequence raises a frame interrupt on its last step. The long 5-step sequence never interrupts.

Software controls the block with one byte-wide control write and one status read. The control write selects the sequence and an interrupt inhibit, and it always restarts the counter. The status read reports the frame flag and clears it. The block drives a CPU IRQ line that it shares with the delta sample channel. That channel reports two facts: whether it still has bytes to fetch, and whether its own interrupt is enabled. When both are true, the sample channel is treated as asserting its interrupt. While it asserts, any clear of the frame flag leaves the shared line alone.

Top module: `frame_seq_irq`

## Requirements
- R1: After reset, the block is in 4-step mode with inhibit clear and the counter at 0. No pulse is driven, the frame flag and cpu_irq are low, and the status byte is zero apart from bit 4.
- R2: In 4-step mode, with the count measured in clock edges since the last counter restart, qtr_tick is high in the cycle after the edges at counts 7457, 14913, 22371 and 29829. half_tick is high after the edges at counts 14913 and 29829.
- R3: In 4-step mode, the counter returns to 0 on the edge that would reach 29830, so the pattern repeats every 29830 cycles (8 quarter and 4 half pulses in two periods).
- R4: In 5-step mode, quarter pulses come at 7457, 14913, 22371 and 37281, and half pulses at 14913 and 29829. The period is 37282 cycles.
- R5: On the 4-step edge at count 29829, with inhibit clear, frame_flag and cpu_irq are set. 5-step mode never sets them.
- R6: While inhibit is set, the frame flag is not set. A control write with bit 6 = 1 clears the frame flag.
- R7: A control write takes bit 7 as the mode (1 = 5-step) and bit 6 as the inhibit. It restarts the counter at 0, so the next quarter pulse comes 7457 cycles after the write edge.
- R8: stat_rdata carries the frame flag in bit 6 and smp_pending in bit 4, with the other bits zero. A status read clears the frame flag on its edge.
- R9: When the flag is cleared by a read or by an inhibit write, cpu_irq falls only if smp_pending and smp_irq_en are not both high. Otherwise cpu_irq keeps its value.
- R10: Every quarter or half pulse lasts exactly one cycle.
- R11: A status read on the same edge as a frame interrupt event leaves frame_flag and cpu_irq set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control byte: bit 7 mode, bit 6 inhibit |
| stat_rd | input | 1 | Status read strobe (clears the frame flag) |
| stat_rdata | output | 8 | Status byte: bit 6 frame flag, bit 4 sample pending |
| smp_pending | input | 1 | Sample channel has bytes remaining |
| smp_irq_en | input | 1 | Sample channel interrupt enable |
| qtr_tick | output | 1 | Quarter-frame pulse |
| half_tick | output | 1 | Half-frame pulse |
| frame_flag | output | 1 | Frame interrupt flag |
| cpu_irq | output | 1 | Shared CPU interrupt line |

## Verification
The bench looks for a pulse that lands one count off, or a wrap that happens one count late. Either error shifts every later pulse and breaks the pulse totals taken over whole periods. It restarts the counter at an arbitrary point to catch a design that keeps counting through a control write. It issues a status read on the exact edge of the interrupt step: a design that lets the clear win would lose that interrupt. It clears the flag while the sample channel asserts: a design that drops cpu_irq there would silently lose the other source's request.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   localparam int unsigned FS_CNT_W = 16;
   localparam int unsigned FS_WRAP4 = 29830;
   localparam int unsigned FS_WRAP5 = 37282;

   typedef enum logic {
      FS_MODE4 = 1'b0,
      FS_MODE5 = 1'b1
   } fs_mode_e;

   // One entry of the step table: count reached, modes it belongs to, outputs it fires.
   typedef struct packed {
      int unsigned pos;
      logic        in4;
      logic        in5;
      logic        qtr;
      logic        half;
      logic        irq;
   } fs_step_t;

   localparam int FS_NSTEP = 6;

   localparam fs_step_t FS_STEPS [FS_NSTEP] = '{
      '{pos: 7457,  in4: 1'b1, in5: 1'b1, qtr: 1'b1, half: 1'b0, irq: 1'b0},
      '{pos: 14913, in4: 1'b1, in5: 1'b1, qtr: 1'b1, half: 1'b1, irq: 1'b0},
      '{pos: 22371, in4: 1'b1, in5: 1'b1, qtr: 1'b1, half: 1'b0, irq: 1'b0},
      '{pos: 29829, in4: 1'b1, in5: 1'b0, qtr: 1'b1, half: 1'b1, irq: 1'b1},
      '{pos: 29829, in4: 1'b0, in5: 1'b1, qtr: 1'b0, half: 1'b1, irq: 1'b0},
      '{pos: 37281, in4: 1'b0, in5: 1'b1, qtr: 1'b1, half: 1'b0, irq: 1'b0}
   };

endpackage

// File: rtl/fseq_counter.sv
module fseq_counter #(
   parameter int unsigned CNT_W = fseq_pkg::FS_CNT_W,
   parameter int unsigned WRAP4 = fseq_pkg::FS_WRAP4,
   parameter int unsigned WRAP5 = fseq_pkg::FS_WRAP5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             mode5,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] nxt_o
);

   localparam logic [CNT_W-1:0] W4 = CNT_W'(WRAP4);
   localparam logic [CNT_W-1:0] W5 = CNT_W'(WRAP5);

   if (WRAP4 >= (64'd1 << CNT_W) || WRAP5 >= (64'd1 << CNT_W)) begin : g_bad_width
      $error("fseq_counter: CNT_W too narrow for the wrap counts");
   end
   if (WRAP4 < 2 || WRAP5 < 2) begin : g_bad_wrap
      $error("fseq_counter: wrap counts must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] nxt;
   logic [CNT_W-1:0] lim;

   assign nxt = cnt_q + CNT_W'(1);
   assign lim = mode5 ? W5 : W4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (nxt >= lim) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= nxt;
      end
   end

   assign cnt_o = cnt_q;
   assign nxt_o = nxt;

   assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

   assert_range4_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mode5 |-> (cnt_q < W4));

   assert_range5_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < W5);

endmodule

// File: rtl/fseq_step_decode.sv
module fseq_step_decode #(
   parameter int unsigned CNT_W     = fseq_pkg::FS_CNT_W,
   parameter int unsigned WRAP4     = fseq_pkg::FS_WRAP4,
   parameter int unsigned WRAP5     = fseq_pkg::FS_WRAP5,
   parameter bit          PULSE_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             mode5,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] nxt,
   output logic             qtr_o,
   output logic             half_o,
   output logic             irq_hit_o
);

   import fseq_pkg::*;

   localparam int NS = FS_NSTEP;

   logic [NS-1:0] live;
   logic [NS-1:0] hit_n;
   logic [NS-1:0] hit_c;
   logic [NS-1:0] q_n, h_n, i_n, q_c, h_c;

   for (genvar i = 0; i < NS; i++) begin : g_step
      localparam logic [CNT_W-1:0] POS = CNT_W'(FS_STEPS[i].pos);
      localparam bit IN4 = FS_STEPS[i].in4;
      localparam bit IN5 = FS_STEPS[i].in5;

      if (IN4 && FS_STEPS[i].pos >= WRAP4) begin : g_bad4
         $error("fseq_step_decode: 4-step position beyond wrap");
      end
      if (IN5 && FS_STEPS[i].pos >= WRAP5) begin : g_bad5
         $error("fseq_step_decode: 5-step position beyond wrap");
      end
      if (FS_STEPS[i].pos == 0) begin : g_bad0
         $error("fseq_step_decode: step at count zero is not allowed");
      end

      assign live[i]  = mode5 ? IN5 : IN4;
      assign hit_n[i] = live[i] && (nxt == POS);
      assign hit_c[i] = live[i] && (cnt == POS);
      assign q_n[i]   = hit_n[i] & FS_STEPS[i].qtr;
      assign h_n[i]   = hit_n[i] & FS_STEPS[i].half;
      assign i_n[i]   = hit_n[i] & FS_STEPS[i].irq;
      assign q_c[i]   = hit_c[i] & FS_STEPS[i].qtr;
      assign h_c[i]   = hit_c[i] & FS_STEPS[i].half;
   end

   assign irq_hit_o = (|i_n) & ~restart;

   if (PULSE_REG) begin : g_reg
      logic qtr_q, half_q;
      logic unused_cmp;
      assign unused_cmp = ^{q_c, h_c};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            qtr_q  <= 1'b0;
            half_q <= 1'b0;
         end else begin
            qtr_q  <= (|q_n) & ~restart;
            half_q <= (|h_n) & ~restart;
         end
      end
      assign qtr_o  = qtr_q;
      assign half_o = half_q;
   end else begin : g_comb
      logic unused_cmp;
      assign unused_cmp = ^{q_n, h_n, clk};
      assign qtr_o  = |q_c;
      assign half_o = |h_c;
   end

   assert_qtr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      qtr_o |=> !qtr_o);

   assert_half_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      half_o |=> !half_o);

   assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!qtr_o && !half_o));

endmodule

// File: rtl/fseq_irq_ctrl.sv
module fseq_irq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic other_act,
   output logic flag_o,
   output logic irq_o
);

   logic flag_q, irq_q;

   // A set on the same edge as a clear wins, so no event is lost.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         irq_q  <= 1'b0;
      end else if (set) begin
         flag_q <= 1'b1;
         irq_q  <= 1'b1;
      end else if (clr) begin
         flag_q <= 1'b0;
         if (!other_act) begin
            irq_q <= 1'b0;
         end
      end
   end

   assign flag_o = flag_q;
   assign irq_o  = irq_q;

   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> (flag_q && irq_q));

   assert_clear_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag_q);

   assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set && other_act && irq_q) |=> irq_q);

   assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_q) |-> $past(clr && !other_act));

endmodule

// File: rtl/frame_seq_irq.sv
module frame_seq_irq #(
   parameter int unsigned CNT_W     = fseq_pkg::FS_CNT_W,
   parameter int unsigned WRAP4     = fseq_pkg::FS_WRAP4,
   parameter int unsigned WRAP5     = fseq_pkg::FS_WRAP5,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned MODE_BIT  = 7,
   parameter int unsigned INH_BIT   = 6,
   parameter int unsigned FLAG_BIT  = 6,
   parameter int unsigned SMP_BIT   = 4,
   parameter bit          PULSE_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_wdata,
   input  logic              stat_rd,
   output logic [DATA_W-1:0] stat_rdata,
   input  logic              smp_pending,
   input  logic              smp_irq_en,
   output logic              qtr_tick,
   output logic              half_tick,
   output logic              frame_flag,
   output logic              cpu_irq
);

   import fseq_pkg::*;

   if (MODE_BIT >= DATA_W || INH_BIT >= DATA_W) begin : g_bad_ctl
      $error("frame_seq_irq: control bit outside the data byte");
   end
   if (MODE_BIT == INH_BIT) begin : g_bad_ctl2
      $error("frame_seq_irq: mode and inhibit share a bit");
   end
   if (FLAG_BIT >= DATA_W || SMP_BIT >= DATA_W || FLAG_BIT == SMP_BIT) begin : g_bad_stat
      $error("frame_seq_irq: status bit placement invalid");
   end

   fs_mode_e mode_q;
   logic     inh_q;
   logic     mode5;
   logic [CNT_W-1:0] cnt, nxt;
   logic     irq_hit, frame_set, frame_clr, smp_act;
   logic     unused_wbits;

   assign unused_wbits = ^ctl_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= FS_MODE4;
         inh_q  <= 1'b0;
      end else if (ctl_wr) begin
         mode_q <= ctl_wdata[MODE_BIT] ? FS_MODE5 : FS_MODE4;
         inh_q  <= ctl_wdata[INH_BIT];
      end
   end

   assign mode5 = (mode_q == FS_MODE5);

   fseq_counter #(
      .CNT_W (CNT_W),
      .WRAP4 (WRAP4),
      .WRAP5 (WRAP5)
   ) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ctl_wr),
      .mode5   (mode5),
      .cnt_o   (cnt),
      .nxt_o   (nxt)
   );

   fseq_step_decode #(
      .CNT_W     (CNT_W),
      .WRAP4     (WRAP4),
      .WRAP5     (WRAP5),
      .PULSE_REG (PULSE_REG)
   ) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (ctl_wr),
      .mode5     (mode5),
      .cnt       (cnt),
      .nxt       (nxt),
      .qtr_o     (qtr_tick),
      .half_o    (half_tick),
      .irq_hit_o (irq_hit)
   );

   assign frame_set = irq_hit & ~inh_q;
   assign frame_clr = stat_rd | (ctl_wr & ctl_wdata[INH_BIT]);
   assign smp_act   = smp_pending & smp_irq_en;

   fseq_irq_ctrl u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set       (frame_set),
      .clr       (frame_clr),
      .other_act (smp_act),
      .flag_o    (frame_flag),
      .irq_o     (cpu_irq)
   );

   always_comb begin
      stat_rdata           = '0;
      stat_rdata[FLAG_BIT] = frame_flag;
      stat_rdata[SMP_BIT]  = smp_pending;
   end

   assert_no_irq5_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_flag) |-> !$past(mode5));

   assert_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_flag) |-> !$past(inh_q));

   assert_inh_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata[INH_BIT]) |=> !frame_flag);

   assert_flag_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_flag) |-> cpu_irq);

endmodule

// File: tb/frame_seq_irq_bench.sv
module frame_seq_irq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic       stat_rd = 1'b0;
   logic [7:0] stat_rdata;
   logic       smp_pending = 1'b0;
   logic       smp_irq_en = 1'b0;
   logic       qtr_tick, half_tick, frame_flag, cpu_irq;

   int n_cmp = 0;
   int n_bad = 0;
   int q_cnt = 0;
   int h_cnt = 0;
   bit rand_smp = 1'b0;
   bit done = 1'b0;

   // model state
   int   m_cnt = 0;
   bit   m_mode = 0, m_inh = 0, m_flag = 0, m_cpu = 0, m_q = 0, m_h = 0;

   always #10 clk = ~clk;

   frame_seq_irq u_frame_seq_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr      (ctl_wr),
      .ctl_wdata   (ctl_wdata),
      .stat_rd     (stat_rd),
      .stat_rdata  (stat_rdata),
      .smp_pending (smp_pending),
      .smp_irq_en  (smp_irq_en),
      .qtr_tick    (qtr_tick),
      .half_tick   (half_tick),
      .frame_flag  (frame_flag),
      .cpu_irq     (cpu_irq)
   );

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit exp_qtr(bit mode, int n);
      if (mode) return (n == 7457 || n == 14913 || n == 22371 || n == 37281);
      return (n == 7457 || n == 14913 || n == 22371 || n == 29829);
   endfunction

   function automatic bit exp_half(int n);
      return (n == 14913 || n == 29829);
   endfunction

   function automatic int wrap_of(bit mode);
      return mode ? 37282 : 29830;
   endfunction

   // reference model and per-cycle comparison
   always @(posedge clk) begin
      bit set, clr, act;
      int n;
      set = 0;
      if (!rst_n) begin
         m_cnt = 0; m_mode = 0; m_inh = 0; m_flag = 0; m_cpu = 0; m_q = 0; m_h = 0;
      end else begin
         m_q = 0; m_h = 0;
         clr = stat_rd || (ctl_wr && ctl_wdata[6]);
         act = smp_pending && smp_irq_en;
         if (ctl_wr) begin
            m_mode = ctl_wdata[7];
            m_inh  = ctl_wdata[6];
            m_cnt  = 0;
         end else begin
            n     = m_cnt + 1;
            m_q   = exp_qtr(m_mode, n);
            m_h   = exp_half(n);
            set   = !m_mode && (n == 29829) && !m_inh;
            m_cnt = (n >= wrap_of(m_mode)) ? 0 : n;
         end
         if (clr) begin
            m_flag = 0;
            if (!act) m_cpu = 0;
         end
         if (set) begin
            m_flag = 1;
            m_cpu  = 1;
         end
      end
      #5;
      if (rst_n) begin
         chk(m_mode ? "R4 qtr" : "R2 qtr", qtr_tick, m_q);
         chk(m_mode ? "R4 half" : "R2 half", half_tick, m_h);
         chk("R5 frame_flag", frame_flag, m_flag);
         chk("R9 cpu_irq", cpu_irq, m_cpu);
         chk("R8 stat_rdata", stat_rdata, {1'b0, m_flag, 1'b0, smp_pending, 4'b0000});
         if (qtr_tick) q_cnt++;
         if (half_tick) h_cnt++;
      end
   end

   always @(negedge clk) begin
      if (rand_smp) begin
         smp_pending <= 1'($urandom);
         smp_irq_en  <= 1'($urandom);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctl(logic [7:0] d);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = d;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic rd_stat();
      @(negedge clk);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4711);
      cyc(3);
      // R1: reset state
      chk("R1 qtr", qtr_tick, 0);
      chk("R1 half", half_tick, 0);
      chk("R1 flag", frame_flag, 0);
      chk("R1 cpu_irq", cpu_irq, 0);
      chk("R1 rdata", stat_rdata, 0);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 after release qtr", qtr_tick, 0);
      chk("R1 after release flag", frame_flag, 0);

      // R2, R3, R5: 4-step over two periods
      rand_smp = 1'b1;
      wr_ctl(8'h00);
      q_cnt = 0; h_cnt = 0;
      cyc(2 * 29830);
      chk("R3 qtr count", q_cnt, 8);
      chk("R3 half count", h_cnt, 4);
      chk("R5 flag set in 4-step", frame_flag, 1);

      // R4, R5: 5-step, flag cleared first
      rd_stat();
      wr_ctl(8'h80);
      q_cnt = 0; h_cnt = 0;
      cyc(44740);
      chk("R4 qtr count", q_cnt, 5);
      chk("R4 half count", h_cnt, 2);
      chk("R5 no flag in 5-step", frame_flag, 0);

      // R11: read on the interrupt edge
      wr_ctl(8'h00);
      cyc(29828);
      stat_rd = 1'b1;
      cyc(1);
      stat_rd = 1'b0;
      chk("R11 flag kept", frame_flag, 1);
      chk("R11 cpu_irq kept", cpu_irq, 1);

      // R6, R9: inhibit write while sample channel asserts
      rand_smp = 1'b0;
      @(negedge clk);
      smp_pending = 1'b1;
      smp_irq_en  = 1'b1;
      wr_ctl(8'h40);
      chk("R6 inhibit clears flag", frame_flag, 0);
      chk("R9 cpu_irq held", cpu_irq, 1);
      @(negedge clk);
      smp_pending = 1'b0;
      rd_stat();
      chk("R9 cpu_irq dropped", cpu_irq, 0);
      cyc(29900);
      chk("R6 inhibited flag", frame_flag, 0);
      chk("R6 inhibited cpu_irq", cpu_irq, 0);

      // R7, R10: restart at an arbitrary point
      rand_smp = 1'b1;
      wr_ctl(8'h00);
      cyc(1000 + ($urandom % 5000));
      wr_ctl(8'h00);
      cyc(7456);
      chk("R7 no early pulse", qtr_tick, 0);
      cyc(1);
      chk("R7 qtr after restart", qtr_tick, 1);
      cyc(1);
      chk("R10 single-cycle qtr", qtr_tick, 0);

      // random mix
      for (int i = 0; i < 10000; i++) begin
         @(negedge clk);
         ctl_wr    = (($urandom % 2500) == 0);
         ctl_wdata = 8'($urandom);
         stat_rd   = (($urandom % 16) == 0);
      end
      @(negedge clk);
      ctl_wr = 1'b0;
      stat_rd = 1'b0;
      cyc(2);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (198000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule